// File: doc/BRIEF.md
# Raster Timing Generator with Scan Control

This block produces the raster timing of a display: horizontal and vertical sync, blanking, a vertical window marker, a per-line fetch kick and a frame marker. It also produces the start address for frame-buffer scanning. It runs on a clock that ticks once per pair of pixels. Every horizontal compare point is counted in pixel pairs. Every vertical compare point is counted in half-lines, and the vertical counter moves on both at a programmable mid-line point and at the end of each line.

Software programs the block through a single-cycle write port. Sixteen timing slots sit at addresses 0 to 15. The scan registers and a control word sit above them. All writes go to a shadow copy, and the whole configuration is copied into the live set in one step at the end of a frame. A change of offsets or timing therefore never takes effect mid-frame. The scan address is a row offset multiplied by a 32-byte-aligned pitch, plus a column offset scaled by the pixel size. The column offset is rounded up so that the result stays on a 32-byte boundary.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal counter steps once per clock from 0 to hperiod+1 and then returns to 0, so a line lasts hperiod+2 clocks. hperiod is in slot 8.
- R2: The vertical counter advances by one on the clock after the horizontal counter equals the half-line point in slot 14. It also advances at each line end. At a line end where v+1 is not below the vertical period in slot 6, it returns to 0 instead, and that edge ends the frame. With an even period, a frame is period/2 lines.
- R3: Each window output is high for counter values in [start, end). When start exceeds end, the window wraps through zero, and when start equals end it is empty. The pairs are: horizontal blank in slots 9 and 10, horizontal sync in slots 12 and 11, vertical blank in slots 1 and 2, vertical sync in slots 5 and 4, and the vwin output in slots 0 and 3. active is high when neither blank window is high.
- R4: The timing slots are addressed in this order: 0 vwin start, 1 vblank start, 2 vblank end, 3 vwin end, 4 vsync end, 5 vsync start, 6 vperiod, 7 pipe delay, 8 hperiod, 9 hblank start, 10 hblank end, 11 hsync end, 12 hsync start, 13 equalization, 14 half-line, 15 serration.
- R5: The control word at address 20 enables hsync only when its bits 5:4 are both 1, and enables vsync only when its bits 1:0 are both 1. A disabled sync output stays low.
- R6: Bit 10 of the control word holds blank high for the whole frame without changing active.
- R7: line_start is high exactly when the horizontal counter equals the pipe delay in slot 7, once per line.
- R8: scan_addr = yoff*(pitch with bits 4:0 cleared) + (xoff rounded up to a multiple of 32>>s) << s. Pitch is at address 16, xoff at 17, yoff at 18, and the size code s is bits 1:0 of address 19, with a code of 3 treated as 2. The result is always a multiple of 32.
- R9: Writes land in a shadow copy. The live configuration, including scan_addr, changes only at a frame end. frame_start is high on the first clock of every frame, where both counters are 0.
- R10: Writes to slots 13 and 15 and to addresses 21 to 31 have no effect on any output.
- R11: During reset both counters and all registers are 0. hsync and vsync are low, scan_addr is 0, and frame_start and line_start are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | DATA_W | Write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Blanking, including forced blank |
| active | output | 1 | Visible display area |
| vwin | output | 1 | Vertical window marker |
| line_start | output | 1 | Per-line fetch kick at the pipe delay |
| frame_start | output | 1 | First clock of a frame |
| scan_addr | output | ADDR_W | Frame-buffer scan start address |

## Verification
The hardest condition to reach from the ports is a write that lands mid-frame while the old live configuration is still driving the outputs. The bench reaches it by waiting for frame_start, writing a new row offset two clocks later, and watching scan_addr hold its old value every clock until the next frame_start. Whole frames are then swept clock by clock against counters rebuilt from the pixel margins, for two geometries whose windows wrap through zero.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [REG_AW-1:0] {
    A_VWIN_S   = 5'd0,
    A_VBLANK_S = 5'd1,
    A_VBLANK_E = 5'd2,
    A_VWIN_E   = 5'd3,
    A_VSYNC_E  = 5'd4,
    A_VSYNC_S  = 5'd5,
    A_VPERIOD  = 5'd6,
    A_PIPE     = 5'd7,
    A_HPERIOD  = 5'd8,
    A_HBLANK_S = 5'd9,
    A_HBLANK_E = 5'd10,
    A_HSYNC_E  = 5'd11,
    A_HSYNC_S  = 5'd12,
    A_HEQ      = 5'd13,
    A_HHALF    = 5'd14,
    A_HSERR    = 5'd15,
    A_PITCH    = 5'd16,
    A_XOFF     = 5'd17,
    A_YOFF     = 5'd18,
    A_PSIZE    = 5'd19,
    A_CTRL     = 5'd20
  } reg_addr_e;

  localparam int CTRL_VS_LO = 0;
  localparam int CTRL_HS_LO = 4;
  localparam int CTRL_FBLNK = 10;
endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [rtg_pkg::REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      load,
  output logic [CNT_W-1:0]          vwin_s,
  output logic [CNT_W-1:0]          vwin_e,
  output logic [CNT_W-1:0]          vblank_s,
  output logic [CNT_W-1:0]          vblank_e,
  output logic [CNT_W-1:0]          vsync_s,
  output logic [CNT_W-1:0]          vsync_e,
  output logic [CNT_W-1:0]          vperiod,
  output logic [CNT_W-1:0]          pipe,
  output logic [CNT_W-1:0]          hperiod,
  output logic [CNT_W-1:0]          hblank_s,
  output logic [CNT_W-1:0]          hblank_e,
  output logic [CNT_W-1:0]          hsync_s,
  output logic [CNT_W-1:0]          hsync_e,
  output logic [CNT_W-1:0]          hhalf,
  output logic [DATA_W-1:0]         pitch,
  output logic [DATA_W-1:0]         xoff,
  output logic [DATA_W-1:0]         yoff,
  output logic [1:0]                psize,
  output logic                      vs_en,
  output logic                      hs_en,
  output logic                      blank_force
);
  import rtg_pkg::*;

  typedef struct packed {
    logic [CNT_W-1:0]  vwin_s, vblank_s, vblank_e, vwin_e, vsync_e, vsync_s, vperiod;
    logic [CNT_W-1:0]  pipe, hperiod, hblank_s, hblank_e, hsync_e, hsync_s, hhalf;
    logic [DATA_W-1:0] pitch, xoff, yoff;
    logic [1:0]        psize;
    logic              vs_en, hs_en, blank_force;
  } cfg_t;

  cfg_t shadow_q, live_q;
  logic [CNT_W-1:0] wr_cnt;
  assign wr_cnt = CNT_W'(wr_data);

  // Shadow copy: written at any time. Slots 13, 15 and unmapped addresses have no storage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_VWIN_S:   shadow_q.vwin_s   <= wr_cnt;
        A_VBLANK_S: shadow_q.vblank_s <= wr_cnt;
        A_VBLANK_E: shadow_q.vblank_e <= wr_cnt;
        A_VWIN_E:   shadow_q.vwin_e   <= wr_cnt;
        A_VSYNC_E:  shadow_q.vsync_e  <= wr_cnt;
        A_VSYNC_S:  shadow_q.vsync_s  <= wr_cnt;
        A_VPERIOD:  shadow_q.vperiod  <= wr_cnt;
        A_PIPE:     shadow_q.pipe     <= wr_cnt;
        A_HPERIOD:  shadow_q.hperiod  <= wr_cnt;
        A_HBLANK_S: shadow_q.hblank_s <= wr_cnt;
        A_HBLANK_E: shadow_q.hblank_e <= wr_cnt;
        A_HSYNC_E:  shadow_q.hsync_e  <= wr_cnt;
        A_HSYNC_S:  shadow_q.hsync_s  <= wr_cnt;
        A_HHALF:    shadow_q.hhalf    <= wr_cnt;
        A_PITCH:    shadow_q.pitch    <= wr_data;
        A_XOFF:     shadow_q.xoff     <= wr_data;
        A_YOFF:     shadow_q.yoff     <= wr_data;
        A_PSIZE:    shadow_q.psize    <= wr_data[1:0];
        A_CTRL: begin
          shadow_q.vs_en       <= &wr_data[CTRL_VS_LO +: 2];
          shadow_q.hs_en       <= &wr_data[CTRL_HS_LO +: 2];
          shadow_q.blank_force <= wr_data[CTRL_FBLNK];
        end
        default: ;
      endcase
    end
  end

  // Live copy: only refreshed at a frame end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    live_q <= '0;
    else if (load) live_q <= shadow_q;
  end

  assert_live_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(live_q));

  assign vwin_s = live_q.vwin_s;     assign vwin_e = live_q.vwin_e;
  assign vblank_s = live_q.vblank_s; assign vblank_e = live_q.vblank_e;
  assign vsync_s = live_q.vsync_s;   assign vsync_e = live_q.vsync_e;
  assign vperiod = live_q.vperiod;   assign pipe = live_q.pipe;
  assign hperiod = live_q.hperiod;   assign hhalf = live_q.hhalf;
  assign hblank_s = live_q.hblank_s; assign hblank_e = live_q.hblank_e;
  assign hsync_s = live_q.hsync_s;   assign hsync_e = live_q.hsync_e;
  assign pitch = live_q.pitch;       assign xoff = live_q.xoff;
  assign yoff = live_q.yoff;         assign psize = live_q.psize;
  assign vs_en = live_q.vs_en;       assign hs_en = live_q.hs_en;
  assign blank_force = live_q.blank_force;
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hperiod,
  input  logic [CNT_W-1:0] hhalf,
  input  logic [CNT_W-1:0] vperiod,
  output logic [CNT_W-1:0] h_cnt,
  output logic [CNT_W-1:0] v_cnt,
  output logic             frame_end
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic h_wrap, half_hit, v_room, v_step;

  assign h_wrap    = {1'b0, h_cnt} >= ({1'b0, hperiod} + ONE);
  assign half_hit  = (h_cnt == hhalf);
  assign v_room    = ({1'b0, v_cnt} + ONE) < {1'b0, vperiod};
  assign v_step    = h_wrap || half_hit;
  assign frame_end = h_wrap && !v_room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      h_cnt <= h_wrap ? '0 : h_cnt + 1'b1;
      if (h_wrap)               v_cnt <= v_room ? v_cnt + 1'b1 : '0;
      else if (half_hit && v_room) v_cnt <= v_cnt + 1'b1;
    end
  end

  assert_h_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> h_cnt == $past(h_cnt) + 1'b1);
  assert_v_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !v_step |=> $stable(v_cnt));
  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (h_cnt == '0 && v_cnt == '0));
endmodule

// File: rtl/rtg_scan_addr.sv
module rtg_scan_addr #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic [DATA_W-1:0] pitch,
  input  logic [DATA_W-1:0] xoff,
  input  logic [DATA_W-1:0] yoff,
  input  logic [1:0]        psize,
  output logic [ADDR_W-1:0] scan_addr
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int XS_W   = DATA_W + 3;

  function automatic logic [ADDR_W-1:0] start_of(
    input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y, input logic [1:0] code);
    logic [1:0]        s;
    logic [XS_W-1:0]   step_m1, xr;
    logic [DATA_W-1:0] pa;
    logic [PROD_W-1:0] row;
    s       = (code == 2'd3) ? 2'd2 : code;
    step_m1 = XS_W'(31) >> s;
    xr      = (XS_W'(x) + step_m1) & ~step_m1;
    pa      = {p[DATA_W-1:5], 5'b0};
    row     = PROD_W'(y) * PROD_W'(pa);
    return ADDR_W'(row) + ADDR_W'(xr << s);
  endfunction

  assign scan_addr = start_of(pitch, xoff, yoff, psize);

  always_comb begin
    assert_scan_align_R8: assert (scan_addr[4:0] == 5'd0);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [rtg_pkg::REG_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic                        hsync,
  output logic                        vsync,
  output logic                        blank,
  output logic                        active,
  output logic                        vwin,
  output logic                        line_start,
  output logic                        frame_start,
  output logic [ADDR_W-1:0]           scan_addr
);
  logic [CNT_W-1:0] vwin_s, vwin_e, vblank_s, vblank_e, vsync_s, vsync_e, vperiod;
  logic [CNT_W-1:0] pipe, hperiod, hblank_s, hblank_e, hsync_s, hsync_e, hhalf;
  logic [DATA_W-1:0] pitch, xoff, yoff;
  logic [1:0] psize;
  logic vs_en, hs_en, blank_force;
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic frame_end, hblank_w, vblank_w;

  // Half-open window [s, e) that wraps through zero when s > e
  function automatic logic in_win(input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] s,
                                  input logic [CNT_W-1:0] e);
    if (s <= e) return (c >= s) && (c < e);
    else        return (c >= s) || (c < e);
  endfunction

  rtg_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(frame_end),
    .vwin_s(vwin_s), .vwin_e(vwin_e), .vblank_s(vblank_s), .vblank_e(vblank_e),
    .vsync_s(vsync_s), .vsync_e(vsync_e), .vperiod(vperiod), .pipe(pipe),
    .hperiod(hperiod), .hblank_s(hblank_s), .hblank_e(hblank_e),
    .hsync_s(hsync_s), .hsync_e(hsync_e), .hhalf(hhalf),
    .pitch(pitch), .xoff(xoff), .yoff(yoff), .psize(psize),
    .vs_en(vs_en), .hs_en(hs_en), .blank_force(blank_force)
  );

  rtg_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hperiod(hperiod), .hhalf(hhalf), .vperiod(vperiod),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_end(frame_end)
  );

  rtg_scan_addr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_scan (
    .pitch(pitch), .xoff(xoff), .yoff(yoff), .psize(psize), .scan_addr(scan_addr)
  );

  assign hblank_w    = in_win(h_cnt, hblank_s, hblank_e);
  assign vblank_w    = in_win(v_cnt, vblank_s, vblank_e);
  assign hsync       = hs_en && in_win(h_cnt, hsync_s, hsync_e);
  assign vsync       = vs_en && in_win(v_cnt, vsync_s, vsync_e);
  assign vwin        = in_win(v_cnt, vwin_s, vwin_e);
  assign active      = !hblank_w && !vblank_w;
  assign blank       = !active || blank_force;
  assign line_start  = (h_cnt == pipe);
  assign frame_start = (h_cnt == '0) && (v_cnt == '0);

  assert_line_kick_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_end) |=> !line_start);
  assert_scan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(scan_addr));
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic hsync, vsync, blank, active, vwin, line_start, frame_start;
  logic [23:0] scan_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model geometry
  int hlen, vper, hss, hes, hsb, heb, pipe, hhalf, vss, ves, vsb, veb, vws, vwe;

  always #10 clk = ~clk;

  raster_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .blank(blank), .active(active), .vwin(vwin),
    .line_start(line_start), .frame_start(frame_start), .scan_addr(scan_addr)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_frame();
    @(negedge clk);
    while (!frame_start) @(negedge clk);
  endtask

  // Interval membership by distance from start, modulo the counter range
  function automatic bit inside_mod(int c, int s, int e, int len);
    return ((c - s + len) % len) < ((e - s + len) % len);
  endfunction

  // Slot order R4: derive register values from pixel margins and write them
  task automatic prog(int xres, int lm, int rm, int hs, int yres, int um, int lmv, int vs);
    int hp;
    hp = (lm + xres + rm + hs) / 2 - 2;
    hss = hp + 1; hsb = hss - rm / 2; hes = hs / 2 - 1; heb = lm / 2 + hes;
    pipe = heb - 1; hhalf = (hp + 2) / 2; hlen = hp + 2;
    vper = (vs + lmv + yres + um) * 2; vss = vper - 2;
    ves = vs * 2 - vper + vss; veb = um * 2 + ves; vsb = vss - lmv * 2;
    vws = (vsb + vss) / 2; vwe = (ves + veb) / 2;
    wr(0, vws); wr(1, vsb); wr(2, veb); wr(3, vwe); wr(4, ves); wr(5, vss); wr(6, vper);
    wr(7, pipe); wr(8, hp); wr(9, hsb); wr(10, heb); wr(11, hes); wr(12, hss);
    wr(13, hs / 4); wr(14, hhalf); wr(15, hss - hes);
  endtask

  // Sweep one whole frame; entered on the negedge where frame_start is high
  task automatic run_frame(bit hs_on, bit vs_on, bit forced);
    int flen;
    flen = (vper / 2) * hlen;
    for (int i = 0; i < flen; i++) begin
      int h, v;
      bit hb, vb;
      h = i % hlen;
      v = 2 * (i / hlen) + ((h > hhalf) ? 1 : 0);
      hb = inside_mod(h, hsb, heb, hlen);
      vb = inside_mod(v, vsb, veb, vper);
      chk("R9 frame_start", frame_start, (i == 0));
      chk("R7 line_start", line_start, (h == pipe));
      chk("R3 R5 hsync", hsync, hs_on && inside_mod(h, hss, hes, hlen));
      chk("R3 R2 R5 vsync", vsync, vs_on && inside_mod(v, vss, ves, vper));
      chk("R3 vwin", vwin, inside_mod(v, vws, vwe, vper));
      chk("R3 R1 active", active, !hb && !vb);
      chk("R6 blank", blank, forced || hb || vb);
      @(negedge clk);
    end
    chk("R2 frame length", frame_start, 1);
  endtask

  function automatic longint exp_addr(int p, int x, int y, int code);
    int s, step, xr;
    s = (code == 3) ? 2 : code;
    step = 32 >> s;
    xr = ((x + step - 1) / step) * step;
    return (longint'(y) * (p & ~31) + (xr << s)) % (1 << 24);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 scan_addr", scan_addr, 0);
    chk("R11 hsync", hsync, 0);
    chk("R11 vsync", vsync, 0);
    chk("R11 frame_start", frame_start, 1);
    chk("R11 line_start", line_start, 1);
    rst_n = 1'b1;

    // Geometry A, both syncs on, windows wrap through zero
    prog(16, 4, 4, 4, 6, 2, 1, 1);
    wr(20, 'h033); wr(16, 'h40); wr(17, 0); wr(18, 0); wr(19, 0);
    wait_frame();
    run_frame(1, 1, 0);

    // R10: writes with no storage or no mapping
    wr(13, 'hFFFF); wr(15, 'hFFFF); wr(25, 'hFFFF); wr(31, 'h0);
    wait_frame();
    chk("R10 scan_addr", scan_addr, 0);
    run_frame(1, 1, 0);

    // R9: mid-frame write stays invisible until the frame ends
    wr(18, 2);
    while (!frame_start) begin
      chk("R9 scan held", scan_addr, 0);
      @(negedge clk);
    end
    chk("R9 scan after boundary", scan_addr, 'h80);

    // R8: scan address sweep over size codes and offsets
    wr(16, 'h4A7);
    for (int code = 0; code < 4; code++) begin
      for (int k = 0; k < 5; k++) begin
        int xs [5] = '{0, 1, 31, 33, 70};
        int y;
        y = (k % 2 == 0) ? 0 : 5;
        wr(19, code); wr(17, xs[k]); wr(18, y);
        wait_frame();
        chk("R8 scan_addr", scan_addr, exp_addr('h4A7, xs[k], y, code));
      end
    end

    // Geometry B, vsync field 01 (off), hsync on, forced blank
    prog(32, 8, 2, 6, 4, 1, 2, 2);
    wr(20, 'h431);
    wait_frame();
    run_frame(1, 0, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule